// File: doc/BRIEF.md
# Paged Auxiliary RAM Address Mapper

This block places a 512-byte on-chip auxiliary RAM at the bottom of a 16-bit external data address space and answers the processor's move-to/from-external-data accesses that land on it. A request carries either a full 16-bit pointer address or an 8-bit register-indirect address. For the short form, a one-bit page register, reachable through a special-function-register (SFR) port at address 0x86, supplies RAM address bit 8. That splits the RAM into a lower and an upper 256-byte page. Both indirect registers share this single bit.

A full-width pointer access is claimed only when it falls in 0x0000..0x01FF and the memory-control lock input is low. An unclaimed access gets no ready from this block, because another decoder answers it, and the RAM is left untouched. Claimed accesses take exactly two cycles. A two-state machine runs them. In ST_IDLE the machine waits. When a valid, claimed request is seen, it takes the IDLE→ACCESS transition and latches the RAM address. Otherwise it stays in IDLE (the IDLE→IDLE transition). In ST_ACCESS, ready is high, read data is driven, and a write commits on the closing edge. The machine then always takes the ACCESS→IDLE transition. The requester holds its request stable until it sees ready, and drops it in the following cycle.

Top module: `edram_mapper`

## Requirements
- R1: A pointer access (req_short=0) whose address is in 0x0000..0x01FF, made while ptr_lock=0, is claimed and reaches RAM byte req_addr[8:0].
- R2: A short access (req_short=1) reaches RAM byte {page bit, req_addr[7:0]}, and req_addr[15:8] has no effect on it.
- R3: A pointer access made while ptr_lock=1 is not claimed: ready stays low and a write leaves the RAM unchanged.
- R4: A pointer access with an address of 0x0200 or above is not claimed: ready stays low and a write leaves the RAM unchanged.
- R5: For a claimed access, ready is high in the second cycle only (the cycle after the request is first seen), and a read returns the addressed byte on rd_data in that cycle.
- R6: A claimed write stores req_wdata on the clock edge that ends the ready cycle, and a later read of the same byte returns it.
- R7: An SFR write with sfr_addr=0x86 loads sfr_wdata[0] into the page bit. SFR writes to any other address leave the page bit unchanged.
- R8: An SFR read with sfr_addr=0x86 returns {7'b0, page bit}. Other SFR addresses read as 0x00.
- R9: After reset the page bit is 0 and ready is low.
- R10: ptr_lock has no effect on short accesses; they are always claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Data access request, held until ready |
| req_short | input | 1 | 1 = 8-bit indirect address, 0 = 16-bit pointer address |
| req_addr | input | 16 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| ptr_lock | input | 1 | Memory-control bit; when 1, pointer accesses are not claimed |
| rd_data | output | 8 | Read data, valid while ready is high |
| ready | output | 1 | Access completes in this cycle |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data |

## Verification
The hardest case to reach is one where the page bit and the access width interact. A page change has to be shown to move short accesses, while pointer accesses to the same low byte stay where they are. An unclaimed write also has to be shown to leave no trace. Only a later claimed read of the same byte can reveal a wrong write. For that reason, the bench first fills the whole RAM with a pattern that is different on each page. It then mixes random SFR page writes and random locked or out-of-range pointer writes among random reads, and checks every read against a shadow copy of the RAM.

// File: rtl/edram_pkg.sv
package edram_pkg;
    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } acc_state_t;
endpackage

// File: rtl/edram_page_reg.sv
module edram_page_reg #(
    parameter int          DATA_W   = 8,
    parameter int          SFR_AW   = 8,
    parameter logic [7:0]  PAGE_SFR = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    output logic              page
);
    logic page_q;
    logic sel;

    assign sel  = (sfr_addr == PAGE_SFR[SFR_AW-1:0]);
    assign page = page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q <= 1'b0;
        end else if (sfr_we && sel) begin
            page_q <= sfr_wdata[0];
        end
    end

    always_comb begin
        sfr_rdata = '0;
        if (sel) begin
            sfr_rdata[0] = page_q;
        end
    end

    // R7: a page write is visible in the following cycle
    a_r7_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_we && sel) |=> (page_q == $past(sfr_wdata[0])));

    // R7: writes elsewhere leave the page bit alone
    a_r7_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_we && sel) |=> $stable(page_q));

    // R8: unused upper bits always read as zero
    always_comb begin
        if (rst_n) begin
            a_r8_upper_zero: assert (sfr_rdata[DATA_W-1:1] == '0);
        end
    end
endmodule

// File: rtl/edram_decode.sv
module edram_decode #(
    parameter int ADDR_W = 16,
    parameter int RAM_AW = 9
) (
    input  logic              req_short,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              ptr_lock,
    input  logic              page,
    output logic              hit,
    output logic [RAM_AW-1:0] ram_addr
);
    localparam int SHORT_W = RAM_AW - 1;

    logic in_range;

    assign in_range = (req_addr[ADDR_W-1:RAM_AW] == '0);

    always_comb begin
        if (req_short) begin
            hit      = 1'b1;
            ram_addr = {page, req_addr[SHORT_W-1:0]};
        end else begin
            hit      = in_range && !ptr_lock;
            ram_addr = req_addr[RAM_AW-1:0];
        end
    end
endmodule

// File: rtl/edram_seq.sv
module edram_seq
    import edram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic hit,
    output logic capture,
    output logic commit,
    output logic ready
);
    acc_state_t state_q, state_d;
    logic       start;

    assign start = (state_q == ST_IDLE) && req_valid && hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_ACCESS;
            ST_ACCESS: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        ready   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture = start;
            end
            ST_ACCESS: begin
                ready  = 1'b1;
                commit = req_write;
            end
            default: begin
                ready = 1'b0;
            end
        endcase
    end

    // R5: a claimed request gets ready in the next cycle
    a_r5_ready_second: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> ready);

    // R5: ready lasts for one cycle only
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
endmodule

// File: rtl/edram_store.sv
module edram_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     capture,
    input  logic                     commit,
    input  logic                     ready,
    input  logic [$clog2(DEPTH)-1:0] addr_in,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (capture) begin
            addr_q <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (commit) begin
            mem[addr_q] <= wdata;
        end
    end

    assign rdata = ready ? mem[addr_q] : '0;

    // R6: the latched address does not move while the access completes
    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !capture);
endmodule

// File: rtl/edram_mapper.sv
module edram_mapper #(
    parameter int         ADDR_W   = 16,
    parameter int         DATA_W   = 8,
    parameter int         DEPTH    = 512,
    parameter int         SFR_AW   = 8,
    parameter logic [7:0] PAGE_SFR = 8'h86
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_short,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ptr_lock,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready,
    input  logic              sfr_we,
    input  logic [SFR_AW-1:0] sfr_addr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata
);
    localparam int RAM_AW = $clog2(DEPTH);

    logic              page;
    logic              hit;
    logic [RAM_AW-1:0] ram_addr;
    logic              capture;
    logic              commit;

    edram_page_reg #(
        .DATA_W   (DATA_W),
        .SFR_AW   (SFR_AW),
        .PAGE_SFR (PAGE_SFR)
    ) u_page (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_we    (sfr_we),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .page      (page)
    );

    edram_decode #(
        .ADDR_W (ADDR_W),
        .RAM_AW (RAM_AW)
    ) u_decode (
        .req_short (req_short),
        .req_addr  (req_addr),
        .ptr_lock  (ptr_lock),
        .page      (page),
        .hit       (hit),
        .ram_addr  (ram_addr)
    );

    edram_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .hit       (hit),
        .capture   (capture),
        .commit    (commit),
        .ready     (ready)
    );

    edram_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .commit  (commit),
        .ready   (ready),
        .addr_in (ram_addr),
        .wdata   (req_wdata),
        .rdata   (rd_data)
    );

    // R3 / R4: an unclaimed request seen while idle never produces ready
    a_r4_unclaimed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !hit && !ready) |=> !ready);

    // R3: locked pointer access is never claimed
    a_r3_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_short && ptr_lock && !ready) |=> !ready);

    // R10: short accesses are always claimed
    a_r10_short_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_short && !ready) |=> ready);
endmodule

// File: tb/edram_mapper_tb.sv
module edram_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_short = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        ptr_lock = 1'b0;
    logic [7:0]  rd_data;
    logic        ready;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_addr = '0;
    logic [7:0]  sfr_wdata = '0;
    logic [7:0]  sfr_rdata;

    int   total = 0;
    int   bad = 0;
    logic model_page = 1'b0;
    logic [7:0] model_mem [512];

    always #5 clk = ~clk;

    edram_mapper u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_short (req_short),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .ptr_lock  (ptr_lock),
        .rd_data   (rd_data),
        .ready     (ready),
        .sfr_we    (sfr_we),
        .sfr_addr  (sfr_addr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata)
    );

    function automatic logic [7:0] fill_val(input int a);
        logic [8:0] aa;
        aa = a[8:0];
        return aa[7:0] ^ (aa[8] ? 8'hA5 : 8'h3C);
    endfunction

    function automatic logic claims(input logic s, input logic [15:0] a, input logic lk);
        return s || ((a < 16'h0200) && !lk);
    endfunction

    function automatic logic [8:0] eff_addr(input logic s, input logic [15:0] a, input logic pg);
        return s ? {pg, a[7:0]} : a[8:0];
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic s, input logic [15:0] a, input logic w,
                          input logic [7:0] wd, input logic lk, input string req);
        logic       cl;
        logic [8:0] ea;
        cl = claims(s, a, lk);
        ea = eff_addr(s, a, model_page);
        @(negedge clk);
        req_valid = 1'b1; req_short = s; req_addr = a;
        req_write = w; req_wdata = wd; ptr_lock = lk;
        #1;
        chk(ready == 1'b0, {req, " R5 no ready in first cycle"}, ready, 0);
        @(negedge clk);
        chk(ready == cl, {req, " ready in second cycle"}, ready, cl);
        if (cl && !w)
            chk(rd_data == model_mem[ea], {req, " R5 read data"}, rd_data, model_mem[ea]);
        @(negedge clk);
        chk(ready == 1'b0, {req, " R5 single ready pulse"}, ready, 0);
        req_valid = 1'b0; req_write = 1'b0;
        if (cl && w) model_mem[ea] = wd;
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
        if (a == 8'h86) model_page = d[0];
    endtask

    task automatic sfr_check(input logic [7:0] a, input string req);
        logic [7:0] exp;
        exp = (a == 8'h86) ? {7'b0, model_page} : 8'h00;
        @(negedge clk);
        sfr_addr = a;
        #1;
        chk(sfr_rdata == exp, req, sfr_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        #1;
        chk(ready == 1'b0, "R9 ready low in reset", ready, 0);
        @(negedge clk);
        rst_n = 1'b1;
        sfr_check(8'h86, "R9 page bit zero after reset");

        // R1 / R6: fill every byte through pointer writes
        for (int i = 0; i < 512; i++) begin
            access(1'b0, 16'(i), 1'b1, fill_val(i), 1'b0, "R6 fill");
        end
        access(1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, "R1 low edge");
        access(1'b0, 16'h01FF, 1'b0, 8'h00, 1'b0, "R1 high edge");
        access(1'b0, 16'h0123, 1'b0, 8'h00, 1'b0, "R1 mid");

        // R4: out of range, read and write
        access(1'b0, 16'h0200, 1'b0, 8'h00, 1'b0, "R4 read 0200");
        access(1'b0, 16'h0200, 1'b1, 8'hEE, 1'b0, "R4 write 0200");
        access(1'b0, 16'hFFFF, 1'b1, 8'hEE, 1'b0, "R4 write FFFF");
        access(1'b0, 16'h0000, 1'b0, 8'h00, 1'b0, "R4 alias byte untouched");
        access(1'b0, 16'h01FF, 1'b0, 8'h00, 1'b0, "R4 alias byte untouched");

        // R3: locked pointer write leaves RAM unchanged
        access(1'b0, 16'h0010, 1'b1, 8'h77, 1'b1, "R3 locked write");
        access(1'b0, 16'h0010, 1'b0, 8'h00, 1'b0, "R3 byte unchanged");

        // R2: short access on page 0, upper byte ignored
        access(1'b1, 16'hAB12, 1'b0, 8'h00, 1'b0, "R2 page0 short read");
        sfr_write(8'h86, 8'hFF);
        sfr_check(8'h86, "R8 page reads 01");
        access(1'b1, 16'h0012, 1'b0, 8'h00, 1'b0, "R2 page1 short read");
        access(1'b1, 16'h5512, 1'b1, 8'h99, 1'b0, "R2 page1 short write");
        access(1'b0, 16'h0112, 1'b0, 8'h00, 1'b0, "R2 pointer sees page1 write");
        access(1'b0, 16'h0012, 1'b0, 8'h00, 1'b0, "R2 page0 byte intact");

        // R7 / R8: other SFR addresses
        sfr_write(8'h87, 8'h00);
        sfr_check(8'h86, "R7 page held after foreign write");
        sfr_check(8'h85, "R8 foreign address reads zero");

        // R10: lock has no effect on short accesses
        access(1'b1, 16'h0040, 1'b0, 8'h00, 1'b1, "R10 short with lock");
        access(1'b1, 16'h0041, 1'b1, 8'h3D, 1'b1, "R10 short write with lock");
        access(1'b0, 16'h0141, 1'b0, 8'h00, 1'b0, "R10 write landed");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int unsigned k;
            logic [15:0] a;
            k = $urandom % 16;
            if (k == 0) begin
                sfr_write(8'h86, 8'($urandom));
            end else if (k == 1) begin
                sfr_write(8'($urandom), 8'($urandom));
                sfr_check(8'h86, "R7 random sfr");
            end else begin
                a = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 512);
                access(1'($urandom), a, 1'($urandom), 8'($urandom),
                       ($urandom % 4 == 0), "R1 R2 R6 random");
            end
        end
        for (int i = 0; i < 512; i++) begin
            access(1'b0, 16'(i), 1'b0, 8'h00, 1'b0, "R6 final sweep");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule